// File: doc/BRIEF.md
# Clock Synthesizer Reconfiguration Port Bridge

This block lets a processor reach the dynamic reconfiguration port of a clock synthesizer through a small set of 32-bit memory-mapped registers. The host side is a plain register strobe: a write strobe with address and data, and a read strobe whose data appears one cycle later. On the synthesizer side the block drives a 7-bit register address, 16-bit write data, an enable pulse and a write enable. It takes back 16-bit read data and a ready flag.

Software launches a port read or a port write with a single write to the command register. It then polls the status word until the busy flag drops. For a read, the returned data sits in the same status word. Two further registers control the synthesizer's reset release and enable, and pick which parent clock feeds it.

Top module: `recfg_port_bridge`

## Requirements
- R1: Offset 0x40 is the reset/enable register. Bit 0 drives `blk_rstn_o`. `synth_en_o` is high only while both bit 1 and bit 0 are set, so writing bit 0 alone keeps the synthesizer disabled. Reads return bits 1:0 with the upper bits zero.
- R2: At offset 0x44, the low SEL_W bits of a write (default 2) drive `clk_sel_o` and read back unchanged. The upper bits read as zero.
- R3: A write to offset 0x70 with bit 29 set, made while the bridge is idle, starts one port transaction. Bit 28 set means read and bit 28 clear means write. Bits 22:16 give the port address and bits 15:0 give the port write data. `port_en_o` is high for exactly one cycle, on the cycle after the host write. `port_we_o` is high with it only for a write.
- R4: Offset 0x74 is the status word. Bit 16 is busy and bits 15:0 hold the captured read data. Busy is set from the cycle after an accepted command write. It stays set until `port_rdy_i` is seen and clears at that same clock edge.
- R5: When `port_rdy_i` completes a port read, `port_rdata_i` is captured into status bits 15:0. Completing a port write leaves the captured data unchanged.
- R6: A command write with bit 29 clear is ignored. It sets no busy and causes no port activity.
- R7: A command write made while busy is set is dropped. It causes no port activity, and it has no effect after the current transaction ends.
- R8: `port_rdy_i` asserted while the bridge is idle changes neither busy nor the captured data.
- R9: The reset `rst_ni` clears every register, busy and the captured data. After reset all outputs are low and all registers read zero.
- R10: Read data appears on `rdata_o` the cycle after `rd_en_i`. Offset 0x70 and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| rd_en_i | input | 1 | Host register read strobe |
| addr_i | input | HOST_AW | Host byte offset |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, valid the cycle after rd_en_i |
| blk_rstn_o | output | 1 | Block reset release (register bit 0) |
| synth_en_o | output | 1 | Synthesizer enable |
| clk_sel_o | output | SEL_W | Parent clock index |
| port_addr_o | output | PORT_AW | Port register address |
| port_wdata_o | output | 16 | Port write data |
| port_en_o | output | 1 | Port transaction enable pulse |
| port_we_o | output | 1 | Port write enable |
| port_rdata_i | input | 16 | Port read data |
| port_rdy_i | input | 1 | Port transaction complete |

## Verification
The bench sends a second command while a slow transaction is still open. A bridge that queued or overwrote the command instead of dropping it would show an extra or corrupted port transaction, or a changed port register. It also pulses ready while the bridge is idle and completes a port write after a read. A design that captured data on every ready would overwrite the status data with garbage. Busy is read straight after the command write and polled to completion, which exposes a busy flag that is set late or cleared early. Each port enable is checked to be one cycle long, carrying the right address, data and write enable.

// File: rtl/recfg_bridge_pkg.sv
package recfg_bridge_pkg;
  localparam int unsigned OFS_RESET   = 'h40;
  localparam int unsigned OFS_CLKSEL  = 'h44;
  localparam int unsigned OFS_CMD     = 'h70;
  localparam int unsigned OFS_STATUS  = 'h74;

  localparam int unsigned PORT_DW     = 16;
  localparam int unsigned CMD_SEL_BIT = 29;
  localparam int unsigned CMD_RD_BIT  = 28;
  localparam int unsigned CMD_ADR_LSB = 16;
  localparam int unsigned STAT_BUSY   = 16;
endpackage

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_rst_i,
  input  logic             wr_sel_i,
  input  logic [31:0]      wdata_i,
  output logic [1:0]       rst_bits_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [1:0]       rst_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= '0;
      sel_q <= '0;
    end else begin
      if (wr_rst_i) rst_q <= wdata_i[1:0];
      if (wr_sel_i) sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign rst_bits_o = rst_q;
  assign sel_o      = sel_q;
endmodule

// File: rtl/bridge_port_fsm.sv
module bridge_port_fsm
  import recfg_bridge_pkg::*;
#(
  parameter int unsigned PORT_AW = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [31:0]        wdata_i,
  output logic [PORT_AW-1:0] port_addr_o,
  output logic [PORT_DW-1:0] port_wdata_o,
  output logic               port_en_o,
  output logic               port_we_o,
  input  logic [PORT_DW-1:0] port_rdata_i,
  input  logic               port_rdy_i,
  output logic               busy_o,
  output logic [PORT_DW-1:0] cap_o
);
  logic               busy_q, en_q, we_q, rd_q;
  logic [PORT_AW-1:0] addr_q;
  logic [PORT_DW-1:0] di_q, cap_q;
  logic               accept;

  // select bit gates launch; busy drops anything else
  assign accept = cmd_wr_i && wdata_i[CMD_SEL_BIT] && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      we_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      di_q   <= '0;
      cap_q  <= '0;
    end else begin
      en_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        en_q   <= 1'b1;
        rd_q   <= wdata_i[CMD_RD_BIT];
        we_q   <= !wdata_i[CMD_RD_BIT];
        addr_q <= wdata_i[CMD_ADR_LSB +: PORT_AW];
        di_q   <= wdata_i[PORT_DW-1:0];
      end else if (busy_q && port_rdy_i) begin
        busy_q <= 1'b0;
        if (rd_q) cap_q <= port_rdata_i;
      end
    end
  end

  assign port_addr_o  = addr_q;
  assign port_wdata_o = di_q;
  assign port_en_o    = en_q;
  assign port_we_o    = en_q && we_q;
  assign busy_o       = busy_q;
  assign cap_o        = cap_q;
endmodule

// File: rtl/bridge_rd_mux.sv
module bridge_rd_mux
  import recfg_bridge_pkg::*;
#(
  parameter int unsigned HOST_AW = 8,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [1:0]         rst_bits_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               busy_i,
  input  logic [PORT_DW-1:0] cap_i,
  output logic [31:0]        rdata_o
);
  logic [31:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (addr_i == HOST_AW'(OFS_RESET))       rd_d[1:0]         = rst_bits_i;
    else if (addr_i == HOST_AW'(OFS_CLKSEL)) rd_d[SEL_W-1:0]   = sel_i;
    else if (addr_i == HOST_AW'(OFS_STATUS)) begin
      rd_d[STAT_BUSY]   = busy_i;
      rd_d[PORT_DW-1:0] = cap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/recfg_port_bridge.sv
module recfg_port_bridge
  import recfg_bridge_pkg::*;
#(
  parameter int unsigned HOST_AW = 8,
  parameter int unsigned PORT_AW = 7,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               blk_rstn_o,
  output logic               synth_en_o,
  output logic [SEL_W-1:0]   clk_sel_o,
  output logic [PORT_AW-1:0] port_addr_o,
  output logic [PORT_DW-1:0] port_wdata_o,
  output logic               port_en_o,
  output logic               port_we_o,
  input  logic [PORT_DW-1:0] port_rdata_i,
  input  logic               port_rdy_i
);
  logic               wr_rst, wr_sel, wr_cmd;
  logic [1:0]         rst_bits;
  logic               busy;
  logic [PORT_DW-1:0] cap_data;

  assign wr_rst = wr_en_i && (addr_i == HOST_AW'(OFS_RESET));
  assign wr_sel = wr_en_i && (addr_i == HOST_AW'(OFS_CLKSEL));
  assign wr_cmd = wr_en_i && (addr_i == HOST_AW'(OFS_CMD));

  bridge_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_rst_i   (wr_rst),
    .wr_sel_i   (wr_sel),
    .wdata_i    (wdata_i),
    .rst_bits_o (rst_bits),
    .sel_o      (clk_sel_o)
  );

  bridge_port_fsm #(.PORT_AW(PORT_AW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (wr_cmd),
    .wdata_i      (wdata_i),
    .port_addr_o  (port_addr_o),
    .port_wdata_o (port_wdata_o),
    .port_en_o    (port_en_o),
    .port_we_o    (port_we_o),
    .port_rdata_i (port_rdata_i),
    .port_rdy_i   (port_rdy_i),
    .busy_o       (busy),
    .cap_o        (cap_data)
  );

  bridge_rd_mux #(.HOST_AW(HOST_AW), .SEL_W(SEL_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .rst_bits_i (rst_bits),
    .sel_i      (clk_sel_o),
    .busy_i     (busy),
    .cap_i      (cap_data),
    .rdata_o    (rdata_o)
  );

  assign blk_rstn_o = rst_bits[0];
  // synthesizer stays off until the block leaves reset
  assign synth_en_o = rst_bits[0] && rst_bits[1];
endmodule

// File: rtl/recfg_port_bridge_chk.sv
module recfg_port_bridge_chk
  import recfg_bridge_pkg::*;
#(
  parameter int unsigned HOST_AW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [HOST_AW-1:0] addr_i,
  input logic [31:0]        wdata_i,
  input logic               busy,
  input logic [PORT_DW-1:0] cap_data,
  input logic               port_en_o,
  input logic               port_we_o,
  input logic               port_rdy_i,
  input logic               blk_rstn_o,
  input logic               synth_en_o
);
  // R3
  en_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_o |=> !port_en_o);
  // R3
  we_with_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we_o |-> port_en_o);
  // R7
  en_on_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_en_o |-> $rose(busy));
  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !port_rdy_i) |=> busy);
  // R4
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && port_rdy_i) |=> !busy);
  // R5
  cap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && port_rdy_i) |=> $stable(cap_data));
  // R6
  no_sel_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == HOST_AW'(OFS_CMD) && !wdata_i[CMD_SEL_BIT] && !busy) |=> !busy);
  // R1
  synth_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synth_en_o |-> blk_rstn_o);
endmodule

bind recfg_port_bridge recfg_port_bridge_chk #(.HOST_AW(HOST_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .busy       (busy),
  .cap_data   (cap_data),
  .port_en_o  (port_en_o),
  .port_we_o  (port_we_o),
  .port_rdy_i (port_rdy_i),
  .blk_rstn_o (blk_rstn_o),
  .synth_en_o (synth_en_o)
);

// File: tb/recfg_port_bridge_tb_top.sv
module recfg_port_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOST_AW = 8;
  localparam int PORT_AW = 7;
  localparam int SEL_W   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0, rd_en = 1'b0;
  logic [HOST_AW-1:0] addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdata;
  logic               blk_rstn, synth_en;
  logic [SEL_W-1:0]   clk_sel;
  logic [PORT_AW-1:0] p_addr;
  logic [15:0]        p_wdata;
  logic               p_en, p_we;
  logic [15:0]        p_rdata = '0;
  logic               p_rdy = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recfg_port_bridge #(.HOST_AW(HOST_AW), .PORT_AW(PORT_AW), .SEL_W(SEL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .blk_rstn_o(blk_rstn), .synth_en_o(synth_en),
    .clk_sel_o(clk_sel), .port_addr_o(p_addr), .port_wdata_o(p_wdata),
    .port_en_o(p_en), .port_we_o(p_we), .port_rdata_i(p_rdata), .port_rdy_i(p_rdy));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard: {we, addr, data}
  logic [23:0] exp_q[$];
  logic [15:0] mem [128];
  int lat = 0;
  bit pend = 0, stray = 0, pend_we = 0;
  int cnt = 0;
  logic [6:0] pend_addr;
  bit prev_en = 0;

  // port model and monitor
  always @(negedge clk) begin
    p_rdy = 1'b0;
    if (stray) begin
      p_rdy = 1'b1; p_rdata = 16'hDEAD; stray = 0;
    end
    if (pend) begin
      if (cnt == 0) begin
        p_rdy = 1'b1;
        p_rdata = pend_we ? 16'hBEEF : mem[pend_addr];
        pend = 0;
      end else cnt--;
    end
    if (p_en && prev_en) chk(0, "R3 enable wider than one cycle", 32'(p_en), 0);
    prev_en = p_en;
    if (p_en) begin
      if (exp_q.size() == 0) chk(0, "R6/R7 unexpected port transaction", {8'h0, p_we, p_addr, p_wdata}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if (e[23]) chk({p_we, p_addr, p_wdata} == e, "R3 port write fields", {8'h0, p_we, p_addr, p_wdata}, {8'h0, e});
        else chk({p_we, p_addr} == e[23:16], "R3 port read fields", {24'h0, p_we, p_addr}, {24'h0, e[23:16]});
      end
      pend = 1; cnt = lat; pend_we = p_we; pend_addr = p_addr;
      if (p_we) mem[p_addr] = p_wdata;
    end
  end

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic poll(output logic [31:0] st);
    st = 32'h1_0000;
    for (int i = 0; i < 60 && st[16]; i++) hr(8'h74, st);
    chk(!st[16], "R4 busy clears after ready", st, st & 32'hFFFF);
  endtask

  task automatic port_write(input logic [6:0] a, input logic [15:0] d);
    exp_q.push_back({1'b1, a, d});
    hw(8'h70, {2'b00, 1'b1, 1'b0, 5'b0, a, d});
  endtask

  task automatic port_read(input logic [6:0] a);
    exp_q.push_back({1'b0, a, 16'h0});
    hw(8'h70, {2'b00, 1'b1, 1'b1, 5'b0, a, 16'h1234});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, st;
    logic [15:0] old;
    for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h0107) ^ 16'h5A3C;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({blk_rstn, synth_en, clk_sel, p_en, p_we} == 0, "R9 outputs low in reset", 32'({blk_rstn, synth_en, clk_sel, p_en, p_we}), 0);
    rst_n = 1;
    hr(8'h40, v); chk(v == 0, "R9 reset reg zero", v, 0);
    hr(8'h44, v); chk(v == 0, "R9 clksel zero", v, 0);
    hr(8'h74, v); chk(v == 0, "R9 status zero", v, 0);

    // R1
    hw(8'h40, 32'h1);
    chk(blk_rstn && !synth_en, "R1 bit0 alone", 32'({blk_rstn, synth_en}), 32'b10);
    hw(8'h40, 32'hFFFF_FFFF);
    chk(blk_rstn && synth_en, "R1 both bits", 32'({blk_rstn, synth_en}), 32'b11);
    hr(8'h40, v); chk(v == 3, "R1 readback", v, 3);
    hw(8'h40, 32'h2);
    chk(!blk_rstn && !synth_en, "R1 bit1 alone gated", 32'({blk_rstn, synth_en}), 0);
    hw(8'h40, 32'h3);

    // R2
    hw(8'h44, 32'h1);
    hr(8'h44, v); chk(v == 1 && clk_sel == 1, "R2 select 1", v, 1);
    hw(8'h44, 32'hFFFF_FFFE);
    hr(8'h44, v); chk(v == 2 && clk_sel == 2, "R2 select upper bits dropped", v, 2);

    // R10
    hr(8'h70, v); chk(v == 0, "R10 command reads zero", v, 0);
    hr(8'h10, v); chk(v == 0, "R10 unmapped reads zero", v, 0);

    // R3 R4 R5 read path
    lat = 2;
    port_read(7'h15);
    hr(8'h74, v); chk(v[16] == 1, "R4 busy right after command", v, 32'h1_0000);
    poll(st); chk(st[15:0] == mem[7'h15], "R5 read data captured", st, 32'(mem[7'h15]));

    // R3 write then R5 write keeps capture
    lat = 0;
    port_write(7'h4E, 16'hC0DE);
    poll(st); chk(st[15:0] == mem[7'h15], "R5 write leaves captured data", st, 32'(mem[7'h15]));
    port_read(7'h4E);
    poll(st); chk(st[15:0] == 16'hC0DE, "R3 written data reads back", st, 32'hC0DE);

    // R6 no select bit
    hw(8'h70, 32'h1005_AAAA);
    hr(8'h74, v); chk(v[16] == 0, "R6 no busy without select", v, 32'(16'hC0DE));
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 no port activity", exp_q.size(), 0);

    // R7 dropped while busy
    lat = 8;
    old = mem[7'h22];
    port_write(7'h11, 16'h1111);
    hw(8'h70, {4'b0010, 5'b0, 7'h22, 16'h9999});
    poll(st);
    chk(exp_q.size() == 0, "R7 dropped command no port access", exp_q.size(), 0);
    lat = 1;
    port_read(7'h22);
    poll(st); chk(st[15:0] == old, "R7 target register untouched", st, 32'(old));

    // R8 stray ready
    @(negedge clk); stray = 1;
    repeat (3) @(negedge clk);
    hr(8'h74, v); chk(v == 32'(old), "R8 idle ready ignored", v, 32'(old));

    // back-to-back zero latency
    lat = 0;
    port_read(7'h7F);
    poll(st); chk(st[15:0] == mem[7'h7F], "R5 top address read", st, 32'(mem[7'h7F]));

    // R9 reset mid-use
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    hr(8'h74, v); chk(v == 0, "R9 status cleared by reset", v, 0);
    hr(8'h44, v); chk(v == 0 && !synth_en, "R9 regs cleared by reset", v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule